// File: doc/BRIEF.md
# Single-Precision Floating-Point Order Comparator

This block decides how two 32-bit single-precision floating-point words relate to each other. It reports A-below-B, B-below-A or equality, and it flags three operand conditions: a not-a-number on either side (the operands then have no order), an infinity on either side, and a zero value on the A side. It has no clock and no state. Its outputs settle within the same cycle that the operands are applied, so it can sit in front of a branch decision, a min/max selector or a sort stage.

Each word holds a sign in bit 31, a biased exponent in bits 30:23 and a fraction in bits 22:0. The ordering treats both zero encodings as one value. Subnormals, normals and infinities are ordered by sign and magnitude. When either operand is a NaN, all relation flags stay low. The exponent and fraction widths are parameters. The defaults give the 32-bit layout.

Top module: `fpcmp_top`

## Requirements
- R1: `unord_o` is 1 exactly when either operand has an all-ones exponent (bits 30:23) and a nonzero fraction (bits 22:0).
- R2: `inf_o` is 1 exactly when either operand has an all-ones exponent and an all-zero fraction.
- R3: `zero_o` is 1 exactly when bits 30:0 of operand A are all zero. The sign of A and all bits of B have no effect on it.
- R4: While `unord_o` is 1, `lt_o`, `gt_o` and `eq_o` are all 0.
- R5: While `unord_o` is 0, exactly one of `lt_o`, `gt_o`, `eq_o` is 1.
- R6: Positive zero and negative zero compare equal, in either operand position.
- R7: For ordered operands of opposite sign that are not both zero, the operand with sign bit 1 is the smaller one.
- R8: For two negative ordered operands, the one with the larger bits 30:0 is the smaller value. Equal bits give equality.
- R9: For two positive ordered operands, including subnormals and infinities, the one with the larger bits 30:0 is the larger value. +inf equals +inf and exceeds every finite value.
- R10: `rel_o` is the 4-bit code {0, A<B, B<A, A==B}. Bit 3 is always 0, and bits 2:0 equal {`lt_o`, `gt_o`, `eq_o`} and are never unknown for known inputs.
- R11: The block is combinational. A change of either operand shows on all outputs without any clock edge.
- R12: No comparison raises an inexact, overflow or underflow indication. The block has no such outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 32 | Operand A word |
| opb_i | input | 32 | Operand B word |
| lt_o | output | 1 | A is less than B |
| gt_o | output | 1 | B is less than A |
| eq_o | output | 1 | A equals B |
| rel_o | output | 4 | Relation code {0, lt, gt, eq} |
| unord_o | output | 1 | Either operand is a NaN |
| inf_o | output | 1 | Either operand is an infinity |
| zero_o | output | 1 | Operand A is a zero of either sign |

## Verification
Uniform random words almost never produce equal operands, signed-zero pairs, infinities, NaNs or neighbours that differ in the last fraction bit. These are exactly the cases where a comparator goes wrong. The stimulus therefore draws each operand from weighted classes (zeros, subnormals, infinities, NaNs, normals) and often derives B from A as a copy, a sign-flipped copy or a one-bit step. Directed vectors add the signed-zero, infinity and NaN pairings that the requirements name.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

    // Per-operand class summary produced by the classifier
    typedef struct packed {
        logic sign;
        logic nan;
        logic inf;
        logic zero;
    } opnd_class_t;

    // Relation outcome
    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
    } rel_t;

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
    import fpcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0]   word_i,
    output opnd_class_t             cls_o,
    output logic [EXP_W+FRAC_W-1:0] mag_o
);
    localparam int W = 1 + EXP_W + FRAC_W;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    opnd_class_t       cls_d;

    always_comb begin
        exp_f      = word_i[W-2 -: EXP_W];
        frac_f     = word_i[FRAC_W-1:0];
        cls_d      = '0;
        cls_d.sign = word_i[W-1];
        cls_d.nan  = (&exp_f) & (|frac_f);
        cls_d.inf  = (&exp_f) & ~(|frac_f);
        cls_d.zero = ~(|exp_f) & ~(|frac_f);
    end

    assign cls_o = cls_d;
    assign mag_o = word_i[W-2:0];
endmodule

// File: rtl/fpcmp_mag_cmp.sv
module fpcmp_mag_cmp #(
    parameter int MAG_W = 31
) (
    input  logic [MAG_W-1:0] mag_a_i,
    input  logic [MAG_W-1:0] mag_b_i,
    output logic             lt_o,
    output logic             eq_o
);
    logic lt_d, eq_d;

    always_comb begin
        lt_d = (mag_a_i < mag_b_i);
        eq_d = (mag_a_i == mag_b_i);
    end

    assign lt_o = lt_d;
    assign eq_o = eq_d;
endmodule

// File: rtl/fpcmp_resolve.sv
module fpcmp_resolve
    import fpcmp_pkg::*;
(
    input  opnd_class_t cls_a_i,
    input  opnd_class_t cls_b_i,
    input  logic        mag_lt_i,
    input  logic        mag_eq_i,
    output rel_t        rel_o
);
    logic mag_gt;
    rel_t rel_d;

    always_comb begin
        mag_gt = ~mag_lt_i & ~mag_eq_i;
        rel_d  = '0;
        if (cls_a_i.nan | cls_b_i.nan) begin
            rel_d = '0;
        end else if (cls_a_i.zero & cls_b_i.zero) begin
            rel_d.eq = 1'b1;
        end else if (cls_a_i.sign != cls_b_i.sign) begin
            rel_d.lt = cls_a_i.sign;
            rel_d.gt = cls_b_i.sign;
        end else if (cls_a_i.sign) begin
            rel_d.lt = mag_gt;
            rel_d.gt = mag_lt_i;
            rel_d.eq = mag_eq_i;
        end else begin
            rel_d.lt = mag_lt_i;
            rel_d.gt = mag_gt;
            rel_d.eq = mag_eq_i;
        end
    end

    assign rel_o = rel_d;
endmodule

// File: rtl/fpcmp_top.sv
module fpcmp_top
    import fpcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] opa_i,
    input  logic [EXP_W+FRAC_W:0] opb_i,
    output logic                  lt_o,
    output logic                  gt_o,
    output logic                  eq_o,
    output logic [3:0]            rel_o,
    output logic                  unord_o,
    output logic                  inf_o,
    output logic                  zero_o
);
    localparam int W     = 1 + EXP_W + FRAC_W;
    localparam int MAG_W = W - 1;

    logic [W-1:0]     word [2];
    opnd_class_t      cls  [2];
    logic [MAG_W-1:0] mag  [2];
    logic             mag_lt, mag_eq;
    rel_t             rel;

    assign word[0] = opa_i;
    assign word[1] = opb_i;

    for (genvar g = 0; g < 2; g++) begin : g_cls
        fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .word_i (word[g]),
            .cls_o  (cls[g]),
            .mag_o  (mag[g])
        );
    end

    fpcmp_mag_cmp #(.MAG_W(MAG_W)) u_mag (
        .mag_a_i (mag[0]),
        .mag_b_i (mag[1]),
        .lt_o    (mag_lt),
        .eq_o    (mag_eq)
    );

    fpcmp_resolve u_res (
        .cls_a_i  (cls[0]),
        .cls_b_i  (cls[1]),
        .mag_lt_i (mag_lt),
        .mag_eq_i (mag_eq),
        .rel_o    (rel)
    );

    assign lt_o    = rel.lt;
    assign gt_o    = rel.gt;
    assign eq_o    = rel.eq;
    assign rel_o   = {1'b0, rel.lt, rel.gt, rel.eq};
    assign unord_o = cls[0].nan | cls[1].nan;
    assign inf_o   = cls[0].inf | cls[1].inf;
    assign zero_o  = cls[0].zero;

    // Checks on settled combinational outputs; skipped while inputs are unknown
    always_comb begin
        if (!$isunknown({opa_i, opb_i})) begin
            p_nan_quiet_r4: assert (!(unord_o && (lt_o || gt_o || eq_o)))
                else $error("R4: relation flag high with NaN operand");
            p_one_rel_r5: assert (unord_o || ($countones({lt_o, gt_o, eq_o}) == 1))
                else $error("R5: ordered operands need exactly one relation flag");
            p_zero_a_only_r3: assert (zero_o == (opa_i[W-2:0] == '0))
                else $error("R3: zero flag does not follow operand A");
            p_code_r10: assert (!$isunknown(rel_o) && rel_o[3] == 1'b0)
                else $error("R10: relation code malformed");
            p_sign_order_r7: assert (unord_o || (opa_i[W-1] == opb_i[W-1]) ||
                                     ((opa_i[W-2:0] == '0) && (opb_i[W-2:0] == '0)) ||
                                     (lt_o == opa_i[W-1]))
                else $error("R7: negative operand not reported smaller");
        end
    end
endmodule

// File: tb/fpcmp_top_bench.sv
module fpcmp_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam int N_RAND     = 4000;

    logic        clk = 1'b0;
    logic [31:0] opa, opb;
    logic        lt, gt, eq, unord, inf, zero;
    logic [3:0]  rel;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpcmp_top u_fpcmp_top (
        .opa_i   (opa),
        .opb_i   (opb),
        .lt_o    (lt),
        .gt_o    (gt),
        .eq_o    (eq),
        .rel_o   (rel),
        .unord_o (unord),
        .inf_o   (inf),
        .zero_o  (zero)
    );

    function automatic bit is_nan(input logic [31:0] x);
        return (x[30:23] == 8'hff) && (x[22:0] != 0);
    endfunction

    function automatic bit is_inf(input logic [31:0] x);
        return (x[30:23] == 8'hff) && (x[22:0] == 0);
    endfunction

    // Signed ordering key: both zeros map to 0
    function automatic longint key(input logic [31:0] x);
        longint m = longint'(x[30:0]);
        return x[31] ? -m : m;
    endfunction

    function automatic logic [3:0] exp_rel(input logic [31:0] a, input logic [31:0] b);
        if (is_nan(a) || is_nan(b)) return 4'b0000;
        if (key(a) < key(b)) return 4'b0100;
        if (key(a) > key(b)) return 4'b0010;
        return 4'b0001;
    endfunction

    function automatic string req_of(input logic [31:0] a, input logic [31:0] b);
        if (is_nan(a) || is_nan(b)) return "R4";
        if (a[30:0] == 0 && b[30:0] == 0) return "R6";
        if (a[31] != b[31]) return "R7";
        if (a[31]) return "R8";
        return "R9";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: opa=%h opb=%h actual=%h expected=%h", req, opa, opb, act, expv);
        end
    endtask

    task automatic check_all();
        logic [3:0] e = exp_rel(opa, opb);
        check(req_of(opa, opb), {28'd0, rel}, {28'd0, e});
        check("R10", {28'd0, rel}, {28'd0, 1'b0, lt, gt, eq});
        check("R5", {31'd0, (unord || ($countones({lt, gt, eq}) == 1))}, 32'd1);
        check("R1", {31'd0, unord}, {31'd0, is_nan(opa) || is_nan(opb)});
        check("R2", {31'd0, inf}, {31'd0, is_inf(opa) || is_inf(opb)});
        check("R3", {31'd0, zero}, {31'd0, opa[30:0] == 0});
    endtask

    task automatic apply(input logic [31:0] a, input logic [31:0] b);
        @(posedge clk);
        #1;
        opa = a;
        opb = b;
        @(negedge clk);
        check_all();
    endtask

    function automatic logic [31:0] rand_op();
        logic [31:0] r = $urandom;
        case ($urandom % 8)
            0: return {r[31], 31'd0};
            1: return {r[31], 8'hff, 23'd0};
            2: return {r[31], 8'hff, r[22:1], 1'b1};
            3: return {r[31], 8'h00, r[22:0]};
            default: return r;
        endcase
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, b;
        void'($urandom(32'd20240611));
        opa = 32'd0;
        opb = 32'd0;
        @(negedge clk);
        // Idle state: +0 vs +0 is equal, A zero
        check("R6", {28'd0, rel}, 32'h1);
        check("R3", {31'd0, zero}, 32'd1);

        // Directed corners
        apply(32'h8000_0000, 32'h0000_0000);           // R6 -0 == +0
        apply(32'h0000_0000, 32'h8000_0000);           // R6
        apply(32'h8000_0000, 32'h1234_5678);           // R3 sign ignored on A
        apply(32'h3f80_0000, 32'h0000_0000);           // R3 B zero does not set flag
        apply(32'h7f80_0000, 32'h7f80_0000);           // R9 +inf == +inf
        apply(32'h7f80_0000, 32'h7f7f_ffff);           // R9 +inf above max finite
        apply(32'hff80_0000, 32'hff7f_ffff);           // R8 -inf below
        apply(32'hff80_0000, 32'h7f80_0000);           // R7
        apply(32'h0000_0001, 32'h0000_0002);           // R9 subnormals
        apply(32'h8000_0001, 32'h0000_0000);           // R7 tiny negative below zero
        apply(32'hbf80_0000, 32'hc000_0000);           // R8 -1 > -2
        apply(32'h7fc0_0000, 32'h3f80_0000);           // R4 NaN A
        apply(32'h3f80_0000, 32'hff80_0001);           // R4 NaN B, R1
        apply(32'h7fc0_0000, 32'h7f80_0000);           // R1 and R2 together

        // R11: change operands between edges, outputs follow without a clock
        @(posedge clk);
        #1;
        opa = 32'h4000_0000;
        opb = 32'h3f80_0000;
        #1;
        check("R11", {28'd0, rel}, 32'h2);
        opb = 32'h4080_0000;
        #1;
        check("R11", {28'd0, rel}, 32'h4);
        // R12: no arithmetic exception outputs exist; relation code bit 3 stays 0
        check("R12", {31'd0, rel[3]}, 32'd0);

        for (int i = 0; i < N_RAND; i++) begin
            a = rand_op();
            case ($urandom % 6)
                0: b = a;
                1: b = a ^ 32'h8000_0000;
                2: b = a + 32'd1;
                3: b = a - 32'd1;
                default: b = rand_op();
            endcase
            apply(a, b);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule